// File: doc/BRIEF.md
# Pulsed Overload Retry Controller

This block sequences the protection of a regulated supply output. It watches an overload indication that has already been brought into the clock domain, and decides from a mode input whether the output should keep running under a current clamp (static limiting) or be shut down and retried on a fixed rhythm (pulsed, or hiccup, limiting). It drives the enable of the output stage and a single overload flag for the rest of the system.

In pulsed mode an overload seen while running turns the output off at once and raises the flag. A timer holds the output off for a long interval, then turns it back on for a short trial whose length is one tenth of the off interval. If any overload sample falls inside the trial, the off/trial cycle repeats; a trial that ends clean returns the block to normal running and drops the flag. In static mode the output stays on and the flag simply mirrors the clamp condition, which allows a start-up into a heavy capacitive load to begin in static mode and move to pulsed mode later. A master enable input, low for standby or thermal shutdown, forces the output off and returns the sequencer to its idle state.

Top module: `ovr_hiccup_ctrl`

## Requirements
- R1: While enabled, in pulsed mode (`static_mode_i` = 0) and running normally, an overload sampled at a clock edge makes `out_en_o` = 0 and `ovl_flag_o` = 1 right after that edge.
- R2: After a trip the output stays off with the flag high for exactly `OFF_CYCLES` cycles, then `out_en_o` returns to 1 for a trial with the flag still 1.
- R3: The trial lasts `ON_CYCLES` = `OFF_CYCLES` / `ON_RATIO` cycles; an overload sampled at any edge of the trial, including its last, sends the block back to the off interval at the end of the trial with the flag still 1.
- R4: A trial with no overload sample ends with `out_en_o` = 1 and `ovl_flag_o` = 0 (normal running) right after its last edge.
- R5: In static mode (`static_mode_i` = 1) while enabled, `out_en_o` is 1 and `ovl_flag_o` equals the value of `ovl_i` sampled at the previous edge.
- R6: A switch from static to pulsed mode at run time with an overload present trips the output at the first edge in pulsed mode.
- R7: A switch to static mode during the off interval or a trial returns the block to normal running at the next edge (`out_en_o` = 1, flag following `ovl_i`).
- R8: With `enable_i` = 0 the outputs are `out_en_o` = 0 and `ovl_flag_o` = 0 after the next edge and the sequencer returns to idle, so re-enabling without an overload gives `out_en_o` = 1 after one edge.
- R9: During and just after reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable_i | input | 1 | Master enable; 0 forces the output off and idles the sequencer |
| static_mode_i | input | 1 | 1 selects static clamp limiting, 0 selects pulsed retry |
| ovl_i | input | 1 | Synchronised overload indication, 1 when the limit is reached |
| out_en_o | output | 1 | Enable for the output stage |
| ovl_flag_o | output | 1 | Overload flag |

## Verification
The hardest state to reach from the ports is the end of a trial, where a single overload sample on the last trial edge must still count as a failure and the off interval must restart with an exact length. The bench is built with a short off interval so it can walk the whole off and trial windows cycle by cycle, placing overload pulses at a middle and at the final trial edge, and switching mode or enable from inside the off and trial windows to reach the run-time transitions.

// File: rtl/ovr_pkg.sv
// Shared types of the pulsed overload retry controller.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package ovr_pkg;

    // Sequencer state: normal running, forced off, trial re-enable.
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_OFF   = 2'd1,
        ST_TRIAL = 2'd2
    } ovr_state_e;

endpackage

// File: rtl/ovr_interval_timer.sv
// Interval timer for the retry sequencer.
// Counts clock cycles from zero after a clear and flags the last cycle of
// either the long off interval or the short trial interval.
// Assumes: OFF_CYCLES >= 2 and 1 <= ON_CYCLES <= OFF_CYCLES.
module ovr_interval_timer #(
    parameter int OFF_CYCLES = 9000,
    parameter int ON_CYCLES  = 900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic use_on_i,
    output logic last_o
);
    localparam int CW = $clog2(OFF_CYCLES + 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CYCLES - 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Cycle counter: cleared on request, otherwise counts up.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Last-cycle decode for the interval in progress.
    always_comb begin
        last_o = use_on_i ? (cnt_q == ON_LAST) : (cnt_q == OFF_LAST);
    end

endmodule

// File: rtl/ovr_trial_judge.sv
// Trial verdict accumulator.
// Remembers whether any overload sample fell inside the current trial and
// presents the verdict including the sample of the current cycle.
// Assumes: the sequencer clears it on every entry to and exit from a trial.
module ovr_trial_judge (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic sample_i,
    input  logic ovl_i,
    output logic fail_o
);
    logic fail_q;

    // Sticky failure bit for the running trial.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            fail_q <= 1'b0;
        end else if (sample_i) begin
            fail_q <= fail_q | ovl_i;
        end
    end

    // Verdict including this cycle's sample.
    always_comb begin
        fail_o = fail_q | (sample_i & ovl_i);
    end

endmodule

// File: rtl/ovr_hiccup_ctrl.sv
// Pulsed overload retry controller (top).
// Static mode: output on, flag mirrors the sampled overload.
// Pulsed mode: trip on overload, hold off OFF_CYCLES, trial ON_CYCLES,
// repeat until a trial passes clean. enable_i low idles everything.
// Assumes: ovl_i is already synchronous to clk; OFF_CYCLES >= ON_RATIO.
module ovr_hiccup_ctrl #(
    parameter int OFF_CYCLES = 9000,
    parameter int ON_RATIO   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic static_mode_i,
    input  logic ovl_i,
    output logic out_en_o,
    output logic ovl_flag_o
);
    import ovr_pkg::*;

    localparam int ON_CYCLES = OFF_CYCLES / ON_RATIO;

    ovr_state_e state_q, state_d;
    logic       out_en_q, out_en_d;
    logic       flag_q, flag_d;
    logic       tmr_clr, tmr_last;
    logic       jdg_clr, jdg_sample, jdg_fail;

    ovr_interval_timer #(
        .OFF_CYCLES (OFF_CYCLES),
        .ON_CYCLES  (ON_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (tmr_clr),
        .use_on_i (state_q == ST_TRIAL),
        .last_o   (tmr_last)
    );

    ovr_trial_judge u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (jdg_clr),
        .sample_i (jdg_sample),
        .ovl_i    (ovl_i),
        .fail_o   (jdg_fail)
    );

    // Next-state and next-output decision of the sequencer.
    always_comb begin
        state_d    = state_q;
        out_en_d   = out_en_q;
        flag_d     = flag_q;
        tmr_clr    = 1'b1;
        jdg_clr    = 1'b1;
        jdg_sample = 1'b0;
        if (!enable_i) begin
            state_d  = ST_RUN;
            out_en_d = 1'b0;
            flag_d   = 1'b0;
        end else if (static_mode_i) begin
            state_d  = ST_RUN;
            out_en_d = 1'b1;
            flag_d   = ovl_i;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (ovl_i) begin
                        state_d  = ST_OFF;
                        out_en_d = 1'b0;
                        flag_d   = 1'b1;
                    end else begin
                        out_en_d = 1'b1;
                        flag_d   = 1'b0;
                    end
                end
                ST_OFF: begin
                    tmr_clr = 1'b0;
                    flag_d  = 1'b1;
                    if (tmr_last) begin
                        state_d  = ST_TRIAL;
                        out_en_d = 1'b1;
                        tmr_clr  = 1'b1;
                    end else begin
                        out_en_d = 1'b0;
                    end
                end
                ST_TRIAL: begin
                    tmr_clr    = 1'b0;
                    jdg_clr    = 1'b0;
                    jdg_sample = 1'b1;
                    out_en_d   = 1'b1;
                    flag_d     = 1'b1;
                    if (tmr_last) begin
                        tmr_clr = 1'b1;
                        jdg_clr = 1'b1;
                        if (jdg_fail) begin
                            state_d  = ST_OFF;
                            out_en_d = 1'b0;
                        end else begin
                            state_d = ST_RUN;
                            flag_d  = 1'b0;
                        end
                    end
                end
                default: begin
                    state_d  = ST_RUN;
                    out_en_d = 1'b0;
                    flag_d   = 1'b0;
                end
            endcase
        end
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            out_en_q <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            out_en_q <= out_en_d;
            flag_q   <= flag_d;
        end
    end

    assign out_en_o   = out_en_q;
    assign ovl_flag_o = flag_q;

endmodule

// File: rtl/ovr_hiccup_ctrl_chk.sv
// Property checker for the retry controller, bound to the top module.
// Observes ports only; keeps one run-length counter for the off window.
module ovr_hiccup_ctrl_chk #(
    parameter int OFF_CYCLES = 9000
) (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic static_mode_i,
    input logic ovl_i,
    input logic out_en_o,
    input logic ovl_flag_o
);
    localparam int CW = $clog2(OFF_CYCLES + 2);

    logic [CW-1:0] off_run_q;

    // Length of the current stretch with output off and flag high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_run_q <= '0;
        end else if (!out_en_o && ovl_flag_o) begin
            if (off_run_q != CW'(OFF_CYCLES + 1)) off_run_q <= off_run_q + 1'b1;
        end else begin
            off_run_q <= '0;
        end
    end

    a_r1_trip_now: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !static_mode_i && out_en_o && !ovl_flag_o && ovl_i)
        |=> (!out_en_o && ovl_flag_o));

    a_r2_off_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        off_run_q <= CW'(OFF_CYCLES));

    a_r4_clear_with_output_on: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ovl_flag_o) && $past(enable_i)) |-> out_en_o);

    a_r5_static_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && static_mode_i) |=> (out_en_o && (ovl_flag_o == $past(ovl_i))));

    a_r8_disable_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!out_en_o && !ovl_flag_o));

endmodule

bind ovr_hiccup_ctrl ovr_hiccup_ctrl_chk #(
    .OFF_CYCLES (OFF_CYCLES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable_i      (enable_i),
    .static_mode_i (static_mode_i),
    .ovl_i         (ovl_i),
    .out_en_o      (out_en_o),
    .ovl_flag_o    (ovl_flag_o)
);

// File: tb/ovr_hiccup_ctrl_tb.sv
// Scoreboard bench: the driver pushes the expected outputs for each edge,
// the monitor pops and compares them half a cycle after that edge.
module ovr_hiccup_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int OFF_T      = 40;
    localparam int RATIO_T    = 10;
    localparam int ON_T       = OFF_T / RATIO_T;

    typedef struct {
        int    due;
        logic  en;
        logic  flag;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b0;
    logic static_mode_i = 1'b0;
    logic ovl_i = 1'b0;
    logic out_en_o, ovl_flag_o;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    ovr_hiccup_ctrl #(
        .OFF_CYCLES (OFF_T),
        .ON_RATIO   (RATIO_T)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable_i),
        .static_mode_i (static_mode_i),
        .ovl_i         (ovl_i),
        .out_en_o      (out_en_o),
        .ovl_flag_o    (ovl_flag_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Edge counter used to time expectations.
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare the outputs against due expectations.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (out_en_o !== e.en || ovl_flag_o !== e.flag) begin
                bad++;
                $display("FAIL %s cycle %0d: out_en=%b flag=%b expected out_en=%b flag=%b",
                         e.tag, cyc, out_en_o, ovl_flag_o, e.en, e.flag);
            end
        end
    end

    // Driver: apply inputs for the next edge and push its expected outputs.
    task automatic step(input logic en, input logic stat, input logic ovl,
                        input logic x_en, input logic x_flag, input string tag);
        exp_t e;
        @(negedge clk);
        enable_i      = en;
        static_mode_i = stat;
        ovl_i         = ovl;
        e.due  = cyc + 1;
        e.en   = x_en;
        e.flag = x_flag;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // Walk a full off window in pulsed mode; last edge opens the trial.
    task automatic off_window(input string tag);
        for (int i = 1; i < OFF_T; i++) step(1, 0, 0, 0, 1, tag);
        step(1, 0, 0, 1, 1, tag);
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        total++;
        if (out_en_o !== 1'b0 || ovl_flag_o !== 1'b0) begin
            bad++;
            $display("FAIL R9 in reset: out_en=%b flag=%b expected 0 0", out_en_o, ovl_flag_o);
        end
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R9");

        // Normal running in pulsed mode
        repeat (3) step(1, 0, 0, 1, 0, "R8");

        // R1: trip, R2: off window, R3: failing trial (middle sample)
        step(1, 0, 1, 0, 1, "R1");
        off_window("R2");
        step(1, 0, 0, 1, 1, "R3");
        step(1, 0, 1, 1, 1, "R3");
        for (int i = 3; i < ON_T; i++) step(1, 0, 0, 1, 1, "R3");
        step(1, 0, 0, 0, 1, "R3");
        off_window("R2");
        // R3 boundary: overload only at the last trial edge
        for (int i = 1; i < ON_T; i++) step(1, 0, 0, 1, 1, "R3");
        step(1, 0, 1, 0, 1, "R3");
        off_window("R2");
        // R4: clean trial returns to normal
        for (int i = 1; i < ON_T; i++) step(1, 0, 0, 1, 1, "R4");
        step(1, 0, 0, 1, 0, "R4");
        step(1, 0, 0, 1, 0, "R4");

        // R5: static mode, flag follows sampled overload, output stays on
        step(1, 1, 1, 1, 1, "R5");
        step(1, 1, 0, 1, 0, "R5");
        step(1, 1, 1, 1, 1, "R5");
        step(1, 1, 1, 1, 1, "R5");
        step(1, 1, 0, 1, 0, "R5");
        step(1, 1, 1, 1, 1, "R5");
        // R6: switch to pulsed with overload present
        step(1, 0, 1, 0, 1, "R6");
        // R7: switch to static during the off window
        step(1, 0, 0, 0, 1, "R7");
        step(1, 1, 0, 1, 0, "R7");
        step(1, 1, 0, 1, 0, "R7");
        // R7: switch to static during a trial, with overload
        step(1, 0, 1, 0, 1, "R1");
        off_window("R2");
        step(1, 0, 0, 1, 1, "R3");
        step(1, 1, 1, 1, 1, "R7");
        step(1, 0, 0, 1, 0, "R7");

        // R8: disable during the off window, then re-enable
        step(1, 0, 1, 0, 1, "R1");
        step(1, 0, 0, 0, 1, "R2");
        step(0, 0, 1, 0, 0, "R8");
        step(0, 1, 1, 0, 0, "R8");
        step(1, 0, 0, 1, 0, "R8");
        step(1, 0, 0, 1, 0, "R8");
        // R8: disable during a trial
        step(1, 0, 1, 0, 1, "R1");
        off_window("R2");
        step(0, 0, 0, 0, 0, "R8");
        step(1, 0, 0, 1, 0, "R8");

        done = 1'b1;
        finish_run();
    end

endmodule